// File: doc/BRIEF.md
# CAN Interrupt Flag and Capture Register

This block collects the interrupt conditions of one CAN controller into a single 32-bit word. A software read port can fetch the word, and the block drives one combined interrupt line. The protocol engine supplies level status signals and single-cycle event pulses. Each signal becomes a flag bit when its bit in an interrupt-enable vector is 1. The flag rules differ by source:

- one flag follows a level;
- some flags set on a rising edge;
- some flags set on any change of an input.

Two bytes of the word capture diagnostic detail. The upper byte holds the bit position at which arbitration was lost. The byte below it holds a bus error code.

Each capture byte locks on its first event and ignores later events until software reads the word. A read of any width acts in one clock cycle. The read returns the word as it stood before the read. In the same cycle, the read clears the sticky flags and unlocks both capture bytes for the next event.

Top module: `can_icr_top`

## Requirements
- R1: After reset, every flag bit is 0, both capture bytes are 0, the read word is zero and `irq` is 0. The edge detectors treat every input as 0 at reset.
- R2: Bit 0 is combinational and equals `rx_full & ien[0]`. It is not sticky, and a read does not clear it.
- R3: Bit 1 sets in the cycle after a clock edge at which `tx1_free` changed from 0 to 1 while `ien[1]` was 1.
- R4: Bit 2 sets after any change, rising or falling, of `err_stat` or `bus_stat`, provided `ien[2]` is 1 in the cycle of the change.
- R5: Bit 3 sets after a 0-to-1 change of `ovr_stat` while `ien[3]` is 1.
- R6: Bit 4 sets after a cycle in which `sleep_mode`, `bus_act` and `ien[4]` are all 1.
- R7: Bit 5 sets after any change of `err_passive` (error-active to error-passive or back) while `ien[5]` is 1.
- R8: `arb_lost` with `ien[6]` set sets bit 6. Whatever `ien[6]` is, `arb_lost` loads `arb_pos` (zero-extended) into bits 31:24 if that byte is unlocked, and then locks the byte. While the byte is locked, later losses leave it unchanged.
- R9: `bus_err` with `ien[7]` set sets bit 7. Whatever `ien[7]` is, `bus_err` loads `err_code` into bits 23:16 if that byte is unlocked, and then locks the byte. While the byte is locked, later errors leave it unchanged.
- R10: A cycle with `rd_en` high has three effects on the next cycle: bits 7:1 become 0, and both capture bytes unlock. An unlocked byte keeps its old value until a new event loads it.
- R11: If a set event for a flag or a capture event happens in the same cycle as a read, the event wins. The flag ends set, and the byte takes the new value and locks.
- R12: `rd_data` always shows the current register value, which is the value before any clear in that cycle. Bits 15:8 read as 0. `irq` is the OR of bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| ien | input | 8 | Interrupt enables for bits 7:0 |
| rx_full | input | 1 | Receive buffer holds a message (level) |
| tx1_free | input | 1 | Transmit buffer 1 available (level) |
| err_stat | input | 1 | Error status (level) |
| bus_stat | input | 1 | Bus status (level) |
| ovr_stat | input | 1 | Data overrun status (level) |
| sleep_mode | input | 1 | Controller is in sleep mode |
| bus_act | input | 1 | Bus activity detected |
| err_passive | input | 1 | Controller is error passive (an error counter above 127) |
| arb_lost | input | 1 | Arbitration lost pulse |
| arb_pos | input | POS_W | Bit position at which arbitration was lost |
| bus_err | input | 1 | Bus error detected pulse |
| err_code | input | CODE_W | Bus error capture code |
| irq | output | 1 | Combined interrupt request |
| rd_data | output | 32 | Register read word |

## Verification
The assertions assume that every input is synchronous to `clk` and sampled once per rising edge. They also assume that the level inputs are 0 while reset is held, so that the first edge after reset is measured from a known 0. The stimulus changes inputs only on the falling clock edge and holds them all at 0 during reset. It then runs random enable patterns and random pulses of `arb_lost`, `bus_err` and `rd_en`. Reads often coincide with events, so the collision rule of R11 is exercised many times.

// File: rtl/can_icr_pkg.sv
package can_icr_pkg;
   localparam int REG_W     = 32;
   localparam int FLAG_N    = 8;
   localparam int CAP_W     = 8;
   localparam int B_RX      = 0;
   localparam int B_TX1     = 1;
   localparam int B_EWARN   = 2;
   localparam int B_OVR     = 3;
   localparam int B_WAKE    = 4;
   localparam int B_EPASS   = 5;
   localparam int B_ARB     = 6;
   localparam int B_BERR    = 7;
   localparam int CODE_LSB  = 16;
   localparam int POS_LSB   = 24;
   localparam int GAP_W     = CODE_LSB - FLAG_N;
endpackage

// File: rtl/can_icr_edge.sv
module can_icr_edge #(
   parameter bit ANY_CHANGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_i;
   end

   generate
      if (ANY_CHANGE) begin : g_any
         assign pulse_o = sig_i ^ prev_q;
         // R4
         any_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sig_i != $past(sig_i)) |-> pulse_o);
      end else begin : g_rise
         assign pulse_o = sig_i & ~prev_q;
         // R3
         rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sig_i) |-> pulse_o);
      end
   endgenerate
endmodule

// File: rtl/can_icr_sticky.sv
module can_icr_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_i | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   // R10
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/can_icr_hold.sv
module can_icr_hold #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic [IN_W-1:0]  data_i,
   input  logic             rel_i,
   output logic [OUT_W-1:0] val_o
);
   localparam int PAD_W = OUT_W - IN_W;

   logic             held_q;
   logic [OUT_W-1:0] val_q;
   logic [OUT_W-1:0] data_ext;
   logic             take;

   generate
      if (IN_W > OUT_W || IN_W < 1) begin : g_bad_width
         $error("can_icr_hold: IN_W must lie in 1..OUT_W");
      end
      if (PAD_W > 0) begin : g_pad
         assign data_ext = {{PAD_W{1'b0}}, data_i};
      end else begin : g_nopad
         assign data_ext = data_i;
      end
   endgenerate

   assign take = evt_i & (~held_q | rel_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         val_q  <= '0;
      end else if (take) begin
         held_q <= 1'b1;
         val_q  <= data_ext;
      end else if (rel_i) begin
         held_q <= 1'b0;
      end
   end

   assign val_o = val_q;

   // R8
   locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !rel_i) |=> $stable(val_o));
   // R11
   load_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i && rel_i) |=> (val_o == $past(data_ext)));
endmodule

// File: rtl/can_icr_top.sv
module can_icr_top
   import can_icr_pkg::*;
#(
   parameter int POS_W  = 5,
   parameter int CODE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic [FLAG_N-1:0]       ien,
   input  logic                    rx_full,
   input  logic                    tx1_free,
   input  logic                    err_stat,
   input  logic                    bus_stat,
   input  logic                    ovr_stat,
   input  logic                    sleep_mode,
   input  logic                    bus_act,
   input  logic                    err_passive,
   input  logic                    arb_lost,
   input  logic [POS_W-1:0]        arb_pos,
   input  logic                    bus_err,
   input  logic [CODE_W-1:0]       err_code,
   output logic                    irq,
   output logic [REG_W-1:0]        rd_data
);
   logic              tx1_rise, ovr_rise, est_chg, bst_chg, ep_chg;
   logic [FLAG_N-1:0] set_vec;
   logic [FLAG_N-1:0] flags;
   logic [CAP_W-1:0]  pos_byte, code_byte;

   generate
      if (POS_W > CAP_W || CODE_W > CAP_W) begin : g_bad_cfg
         $error("can_icr_top: capture inputs wider than a byte");
      end
   endgenerate

   can_icr_edge #(.ANY_CHANGE(1'b0)) u_tx1 (
      .clk(clk), .rst_n(rst_n), .sig_i(tx1_free), .pulse_o(tx1_rise));
   can_icr_edge #(.ANY_CHANGE(1'b0)) u_ovr (
      .clk(clk), .rst_n(rst_n), .sig_i(ovr_stat), .pulse_o(ovr_rise));
   can_icr_edge #(.ANY_CHANGE(1'b1)) u_est (
      .clk(clk), .rst_n(rst_n), .sig_i(err_stat), .pulse_o(est_chg));
   can_icr_edge #(.ANY_CHANGE(1'b1)) u_bst (
      .clk(clk), .rst_n(rst_n), .sig_i(bus_stat), .pulse_o(bst_chg));
   can_icr_edge #(.ANY_CHANGE(1'b1)) u_ep (
      .clk(clk), .rst_n(rst_n), .sig_i(err_passive), .pulse_o(ep_chg));

   always_comb begin
      set_vec          = '0;
      set_vec[B_TX1]   = tx1_rise & ien[B_TX1];
      set_vec[B_EWARN] = (est_chg | bst_chg) & ien[B_EWARN];
      set_vec[B_OVR]   = ovr_rise & ien[B_OVR];
      set_vec[B_WAKE]  = sleep_mode & bus_act & ien[B_WAKE];
      set_vec[B_EPASS] = ep_chg & ien[B_EPASS];
      set_vec[B_ARB]   = arb_lost & ien[B_ARB];
      set_vec[B_BERR]  = bus_err & ien[B_BERR];
   end

   assign flags[B_RX] = rx_full & ien[B_RX];

   generate
      for (genvar i = 1; i < FLAG_N; i++) begin : g_flag
         can_icr_sticky u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(set_vec[i]),
            .clr_i(rd_en), .flag_o(flags[i]));
      end
   endgenerate

   can_icr_hold #(.IN_W(POS_W), .OUT_W(CAP_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .evt_i(arb_lost), .data_i(arb_pos),
      .rel_i(rd_en), .val_o(pos_byte));
   can_icr_hold #(.IN_W(CODE_W), .OUT_W(CAP_W)) u_code (
      .clk(clk), .rst_n(rst_n), .evt_i(bus_err), .data_i(err_code),
      .rel_i(rd_en), .val_o(code_byte));

   assign rd_data = {pos_byte, code_byte, {GAP_W{1'b0}}, flags};
   assign irq     = |flags;

   // R10
   read_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && set_vec == '0) |=> (rd_data[FLAG_N-1:1] == '0));
endmodule

// File: tb/sim_can_icr_top.sv
module sim_can_icr_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  ien = '0;
   logic        rx_full = 0, tx1_free = 0, err_stat = 0, bus_stat = 0;
   logic        ovr_stat = 0, sleep_mode = 0, bus_act = 0, err_passive = 0;
   logic        arb_lost = 0, bus_err = 0;
   logic [4:0]  arb_pos = '0;
   logic [7:0]  err_code = '0;
   logic        irq;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   can_icr_top #(.POS_W(5), .CODE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ien(ien),
      .rx_full(rx_full), .tx1_free(tx1_free), .err_stat(err_stat),
      .bus_stat(bus_stat), .ovr_stat(ovr_stat), .sleep_mode(sleep_mode),
      .bus_act(bus_act), .err_passive(err_passive), .arb_lost(arb_lost),
      .arb_pos(arb_pos), .bus_err(bus_err), .err_code(err_code),
      .irq(irq), .rd_data(rd_data));

   // reference model state
   bit [7:1] m_flag;
   bit [7:0] m_pos, m_code;
   bit       m_pos_lock, m_code_lock;
   bit       p_tx, p_est, p_bst, p_ovr, p_ep;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flag = '0; m_pos = 0; m_code = 0; m_pos_lock = 0; m_code_lock = 0;
         p_tx = 0; p_est = 0; p_bst = 0; p_ovr = 0; p_ep = 0;
      end else begin
         bit [7:1] s;
         s = '0;
         s[1] = ien[1] && tx1_free && !p_tx;
         s[2] = ien[2] && ((err_stat != p_est) || (bus_stat != p_bst));
         s[3] = ien[3] && ovr_stat && !p_ovr;
         s[4] = ien[4] && sleep_mode && bus_act;
         s[5] = ien[5] && (err_passive != p_ep);
         s[6] = ien[6] && arb_lost;
         s[7] = ien[7] && bus_err;
         m_flag = (rd_en ? 7'b0 : m_flag) | s;
         if (arb_lost && (!m_pos_lock || rd_en)) begin
            m_pos = {3'b000, arb_pos}; m_pos_lock = 1;
         end else if (rd_en) m_pos_lock = 0;
         if (bus_err && (!m_code_lock || rd_en)) begin
            m_code = err_code; m_code_lock = 1;
         end else if (rd_en) m_code_lock = 0;
         p_tx = tx1_free; p_est = err_stat; p_bst = bus_stat;
         p_ovr = ovr_stat; p_ep = err_passive;
      end
   end

   function automatic string tag_of(int b);
      case (b)
         0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
         4: return "R6";  5: return "R7";  6: return "R8";  default: return "R9";
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, 2 ns after the rising edge
   bit cmp_on = 0;
   always @(posedge clk) begin
      #2;
      if (cmp_on) begin
         logic [31:0] e;
         e = {m_pos, m_code, 8'h00, m_flag, rx_full & ien[0]};
         for (int b = 0; b < 8; b++) chk(tag_of(b), 32'(rd_data[b]), 32'(e[b]));
         chk("R12", 32'(rd_data[15:8]), 32'h0);
         chk("R9", 32'(rd_data[23:16]), 32'(e[23:16]));
         chk("R8", 32'(rd_data[31:24]), 32'(e[31:24]));
         chk("R12", 32'(irq), 32'(|e[7:0]));
      end
   end

   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read();
      rd_en = 1; step(); rd_en = 0;
   endtask

   initial begin : watchdog
      #900000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      step(4);
      rst_n = 1;
      #1 chk("R1", rd_data, 32'h0);
      chk("R1", 32'(irq), 32'h0);
      step();
      cmp_on = 1;
      ien = 8'hFF;
      // R2 level receive flag
      rx_full = 1; step(); #1 chk("R2", 32'(rd_data[0]), 32'h1);
      do_read(); #1 chk("R2", 32'(rd_data[0]), 32'h1);
      rx_full = 0; step();
      // R3 transmit rising edge, then read clear (R10)
      tx1_free = 1; step(); #1 chk("R3", 32'(rd_data[1]), 32'h1);
      do_read(); #1 chk("R10", 32'(rd_data[1]), 32'h0);
      step(3); #1 chk("R3", 32'(rd_data[1]), 32'h0);
      tx1_free = 0; step();
      // R4 falling change of err_stat
      err_stat = 1; step(); do_read();
      err_stat = 0; step(); #1 chk("R4", 32'(rd_data[2]), 32'h1);
      do_read();
      // R4 change with enable off has no effect
      ien[2] = 0; bus_stat = 1; step(); ien[2] = 1; step();
      #1 chk("R4", 32'(rd_data[2]), 32'h0);
      // R8 capture locks
      arb_lost = 1; arb_pos = 5'd13; step();
      arb_pos = 5'd7; step(); arb_lost = 0; step();
      #1 chk("R8", 32'(rd_data[31:24]), 32'd13);
      // R11 event during read wins
      arb_lost = 1; arb_pos = 5'd21; bus_err = 1; err_code = 8'hA5; rd_en = 1;
      step(); arb_lost = 0; bus_err = 0; rd_en = 0;
      #1 chk("R11", 32'(rd_data[31:24]), 32'd21);
      chk("R11", 32'(rd_data[7:6]), 32'h3);
      do_read();
      // R9 disabled enable still captures, no flag
      ien[7] = 0; bus_err = 1; err_code = 8'h3C; step(); bus_err = 0; ien[7] = 1;
      #1 chk("R9", 32'(rd_data[23:16]), 32'h3C);
      chk("R9", 32'(rd_data[7]), 32'h0);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         ien         = 8'($urandom);
         rx_full     = 1'($urandom);
         if ($urandom % 4 == 0) tx1_free    = ~tx1_free;
         if ($urandom % 5 == 0) err_stat    = ~err_stat;
         if ($urandom % 5 == 0) bus_stat    = ~bus_stat;
         if ($urandom % 4 == 0) ovr_stat    = ~ovr_stat;
         if ($urandom % 6 == 0) err_passive = ~err_passive;
         sleep_mode  = ($urandom % 3 == 0);
         bus_act     = ($urandom % 3 == 0);
         arb_lost    = ($urandom % 4 == 0);
         arb_pos     = 5'($urandom);
         bus_err     = ($urandom % 4 == 0);
         err_code    = 8'($urandom);
         rd_en       = ($urandom % 3 == 0);
         step();
      end
      rd_en = 0; arb_lost = 0; bus_err = 0;
      step(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule